// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host side of a link to an 8-bit serial analog-to-digital converter. The link has three wires: an active-low chip select, a serial clock that the host drives, and one serial data line back from the converter. When it gets a start request, the controller pulls chip select low and waits a setup interval. It then drives exactly eight clock pulses and shifts in eight bits, most significant bit first. It presents the byte on a parallel output with a one-cycle valid strobe. Last, it releases chip select and holds the link idle for a guard interval, so the converter has time to finish the conversion that the access just started.

The converter returns the result of the conversion that the previous access started, and every access starts the next conversion. Because of this, the first result after reset has no meaning, and the controller flags it as stale. A start request that arrives while an access or guard interval is still running is held. It is served once the guard interval ends. Any further requests that arrive before then merge into that single held request. All timing is set by parameters counted in host clock cycles. At a 5 ns host clock, the defaults give 1.4 µs of setup, clock phases of 250 ns, and a guard of 17 µs.

Top module: `sadc_reader`

## Requirements
- R1: While reset is held and right after it, cs_no is 1, sclk_o is 0, busy_o is 0 and valid_o is 0.
- R2: After a start, cs_no stays low for exactly SETUP_CYC host cycles (at least 1400 ns) before the first rising edge of sclk_o.
- R3: Each access drives exactly 8 pulses on sclk_o. Every high phase lasts HALF_CYC cycles, and every low phase between two pulses also lasts HALF_CYC cycles (each at least 244 ns).
- R4: sdo_i is sampled on each rising edge of sclk_o and shifted in MSB first: the first sample goes to data_o bit 7 and the eighth to bit 0. data_o changes only in the cycle where valid_o is 1. valid_o pulses for one cycle, in the first cycle that cs_no is high again.
- R5: sclk_o is 0 whenever cs_no is 1, and cs_no rises on the same edge as the eighth falling edge of sclk_o.
- R6: Once cs_no rises, it stays high for at least GUARD_CYC cycles (at least 17000 ns). busy_o is 1 whenever cs_no is 0 and for the whole guard interval.
- R7: A start_i pulse that arrives while busy_o is 1 is held and begins exactly one access after the guard interval. Several such pulses produce only one access.
- R8: stale_o is 1 together with the first valid_o after reset and 0 with every later valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one read access |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | An access or guard interval is in progress |
| valid_o | output | 1 | One-cycle strobe: data_o holds a new byte |
| data_o | output | W | Byte read by the last access |
| stale_o | output | 1 | The byte on data_o is the meaningless first read after reset |

## Verification
The bench models the converter. The model loads its last conversion when chip select falls, shifts on each falling clock edge, and starts a new conversion on the eighth edge. It then checks that every returned byte is the value presented one access earlier. A controller that sampled on the falling edge would return bytes shifted by one bit. A controller that lost a bit would drop the LSB. The bench measures the length of every phase of chip select and the serial clock. An off-by-one phase counter would show up as a setup or half-period one cycle short or long. A controller that ended the guard early would show up as a chip-select-high run below the minimum. Start pulses sent during the guard interval check that a held request is neither lost nor doubled. The first read checks that the stale flag is raised exactly once.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_GUARD
  } rd_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sadc_phase_timer.sv
module sadc_phase_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == last_i);
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
  parameter int unsigned W         = 8,
  parameter int unsigned HALF_CYC  = 50,
  parameter int unsigned SETUP_CYC = 280,
  parameter int unsigned GUARD_CYC = 3400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         sdo_i,
  output logic         cs_no,
  output logic         sclk_o,
  output logic         busy_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         stale_o
);
  import sadc_pkg::*;

  localparam int unsigned MAX_CYC = max3(HALF_CYC, SETUP_CYC, GUARD_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned BIT_W   = $clog2(W);

  rd_state_e        state_q, state_d;
  logic             pend_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] last;
  logic             done;
  logic             finish;
  logic             capture;
  logic [W-1:0]     word;
  logic             first_q;

  always_comb begin
    unique case (state_q)
      ST_SETUP:    last = CNT_W'(SETUP_CYC - 1);
      ST_HI, ST_LO: last = CNT_W'(HALF_CYC - 1);
      ST_GUARD:    last = CNT_W'(GUARD_CYC - 1);
      default:     last = '0;
    endcase
  end

  sadc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_d != state_q),
    .last_i    (last),
    .done_o    (done)
  );

  assign finish = (state_q == ST_HI) && done && (bit_q == BIT_W'(W - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i || pend_q) state_d = ST_SETUP;
      ST_SETUP: if (done) state_d = ST_HI;
      ST_HI:    if (done) state_d = finish ? ST_GUARD : ST_LO;
      ST_LO:    if (done) state_d = ST_HI;
      ST_GUARD: if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // sample on the rising serial edge, one half-period after the device shifted
  assign capture = (state_d == ST_HI) && (state_q != ST_HI);

  sadc_capture #(.W(W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (capture),
    .bit_i   (sdo_i),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE)  pend_q <= 1'b0;
      else if (start_i)        pend_q <= 1'b1;
      if (state_q == ST_SETUP)            bit_q <= '0;
      else if (state_q == ST_HI && done)  bit_q <= bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      stale_o <= 1'b0;
      first_q <= 1'b1;
    end else begin
      valid_o <= finish;
      if (finish) begin
        data_o  <= word;
        stale_o <= first_q;
        first_q <= 1'b0;
      end
    end
  end

  assign cs_no  = !(state_q == ST_SETUP || state_q == ST_HI || state_q == ST_LO);
  assign sclk_o = (state_q == ST_HI);
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int unsigned W         = 8,
  parameter int unsigned GUARD_CYC = 3400
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cs_no,
  input logic         sclk_o,
  input logic         busy_o,
  input logic         valid_o,
  input logic [W-1:0] data_o,
  input logic         stale_o
);
  localparam int unsigned RUN_W = $clog2(GUARD_CYC + 2);

  logic [RUN_W-1:0] hi_run_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= RUN_W'(GUARD_CYC);
      seen_q   <= 1'b0;
    end else begin
      if (!cs_no)                            hi_run_q <= '0;
      else if (hi_run_q < RUN_W'(GUARD_CYC)) hi_run_q <= hi_run_q + 1'b1;
      if (valid_o) seen_q <= 1'b1;
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_valid_at_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !$past(cs_no)));

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != $past(data_o)) |-> valid_o);

  p_busy_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  p_guard_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_run_q >= RUN_W'(GUARD_CYC)));

  p_stale_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> !stale_o);

  p_stale_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !seen_q) |-> stale_o);
endmodule

bind sadc_reader sadc_reader_chk #(.W(W), .GUARD_CYC(GUARD_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .data_o  (data_o),
  .stale_o (stale_o)
);

// File: tb/sadc_reader_test.sv
module sadc_reader_test;
  localparam int W         = 8;
  localparam int HALF_CYC  = 50;
  localparam int SETUP_CYC = 280;
  localparam int GUARD_CYC = 3400;
  localparam int CLK_NS    = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic sdo_i = 1'b0;
  logic cs_no, sclk_o, busy_o, valid_o, stale_o;
  logic [W-1:0] data_o;

  always #2.5 clk = ~clk;

  sadc_reader #(.W(W), .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .GUARD_CYC(GUARD_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sdo_i(sdo_i),
    .cs_no(cs_no), .sclk_o(sclk_o), .busy_o(busy_o), .valid_o(valid_o),
    .data_o(data_o), .stale_o(stale_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic [W-1:0] dev_conv = 8'h3C;
  logic [W-1:0] dev_sr = '0;
  logic [W-1:0] ana_val = '0;
  int dev_falls = 0;
  logic dm_cs = 1'b1, dm_sclk = 1'b0;
  always @(cs_no or sclk_o) begin
    if (dm_cs && !cs_no) begin
      dev_sr = dev_conv;
      sdo_i = dev_sr[W-1];
      dev_falls = 0;
    end else if (dm_sclk && !sclk_o) begin
      dev_falls++;
      dev_sr = dev_sr << 1;
      sdo_i = dev_sr[W-1];
      if (dev_falls == W) dev_conv = ana_val;
    end
    dm_cs = cs_no;
    dm_sclk = sclk_o;
  end

  // scoreboard
  logic [W:0] exp_q[$];
  logic [W-1:0] prev_ana = 8'h3C;
  bit first_rd = 1'b1;
  int cs_falls = 0;
  int sclk_idle_bad = 0;

  task automatic push_expect(input logic [W-1:0] a);
    ana_val = a;
    exp_q.push_back({first_rd, prev_ana});
    first_rd = 1'b0;
    prev_ana = a;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic do_access(input logic [W-1:0] a);
    push_expect(a);
    pulse_start();
    @(negedge clk);
    while (!valid_o) @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  // timing monitor and result monitor
  logic pcs = 1'b1, psclk = 1'b0;
  int cs_lo_run = 0, cs_hi_run = 1000000, sc_lo_run = 0, sc_hi_run = 0, pulses = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_no && sclk_o) sclk_idle_bad++;
      if (pcs && !cs_no) begin
        check(cs_hi_run >= GUARD_CYC && cs_hi_run * CLK_NS >= 17000, "R6 guard", cs_hi_run, GUARD_CYC);
        cs_falls++;
        pulses = 0;
      end
      if (!psclk && sclk_o) begin
        if (pulses == 0)
          check(cs_lo_run == SETUP_CYC && cs_lo_run * CLK_NS >= 1400, "R2 setup", cs_lo_run, SETUP_CYC);
        else
          check(sc_lo_run == HALF_CYC && sc_lo_run * CLK_NS >= 244, "R3 low phase", sc_lo_run, HALF_CYC);
      end
      if (psclk && !sclk_o) begin
        check(sc_hi_run == HALF_CYC && sc_hi_run * CLK_NS >= 244, "R3 high phase", sc_hi_run, HALF_CYC);
        pulses++;
      end
      if (!pcs && cs_no) begin
        check(pulses == W, "R3 pulse count", pulses, W);
        check(!sclk_o, "R5 release on last fall", sclk_o, 0);
      end
      if (valid_o) begin
        logic [W:0] e;
        check(cs_no && !pcs, "R4 strobe at release", cs_no, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", data_o, -1);
        end else begin
          e = exp_q.pop_front();
          check(data_o == e[W-1:0], "R4 data", data_o, e[W-1:0]);
          check(stale_o == e[W], "R8 stale flag", stale_o, e[W]);
        end
      end
      cs_lo_run = (!cs_no) ? ((pcs) ? 1 : cs_lo_run + 1) : 0;
      cs_hi_run = (cs_no) ? ((!pcs) ? 1 : cs_hi_run + 1) : 0;
      sc_lo_run = (!sclk_o) ? ((psclk) ? 1 : sc_lo_run + 1) : 0;
      sc_hi_run = (sclk_o) ? ((!psclk) ? 1 : sc_hi_run + 1) : 0;
      pcs = cs_no;
      psclk = sclk_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_no == 1'b1 && sclk_o == 1'b0, "R1 lines in reset", {cs_no, sclk_o}, 2);
    check(busy_o == 1'b0 && valid_o == 1'b0, "R1 status in reset", {busy_o, valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_no == 1'b1 && sclk_o == 1'b0 && busy_o == 1'b0 && valid_o == 1'b0,
          "R1 after reset", {cs_no, sclk_o, busy_o, valid_o}, 8);

    do_access(8'hA5);
    do_access(8'hFF);
    do_access(8'h00);
    do_access(8'h5A);
    do_access(8'h80);

    // R7: requests during the guard are held and merged
    push_expect(8'h01);
    pulse_start();
    @(negedge clk);
    while (!valid_o) @(negedge clk);
    repeat (50) @(negedge clk);
    check(busy_o == 1'b1 && cs_no == 1'b1, "R6 busy in guard", busy_o, 1);
    push_expect(8'hC3);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    check(cs_no == 1'b1, "R7 held during guard", cs_no, 1);
    while (cs_no) @(negedge clk);
    while (!valid_o) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (200) @(negedge clk);
    check(cs_no == 1'b1 && busy_o == 1'b0, "R7 no extra access", busy_o, 0);

    do_access(8'h7E);
    repeat (20) @(negedge clk);

    check(cs_falls == 8, "R7 access count", cs_falls, 8);
    check(exp_q.size() == 0, "R4 results pending", exp_q.size(), 0);
    check(sclk_idle_bad == 0, "R5 clock while deselected", sclk_idle_bad, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule